// File: doc/BRIEF.md
# Lockable Threshold Write Guard

This block guards a word-addressed non-volatile array against writes. It keeps one threshold address and a one-way lock bit. Any word address equal to or above the threshold counts as protected, and every address below it stays writable. A serial front end shifts in each instruction and passes it here as a single-cycle strobe. The strobe carries the two opcode bits, the address field (one bit wider than a word address), the level of the program-enable pin, and the level of the pin that chooses between the protect register and the memory array.

The block runs the five protect-side instructions: read back the threshold, arm, clear, load and lock. The write-type instructions (clear and load) take effect only after an arm instruction has been accepted in the same chip selection. Lock freezes the threshold until power-on reset. A separate query port compares any word address against the threshold in the same cycle. The array write path uses this result to block stores.

Top module: `wp_threshold_guard`

## Requirements
- R1: Reset (synchronous, active high) gives threshold all ones (127), lock clear, arm clear, and `cmd_ack` and `rd_valid` low. So only word 127 is protected.
- R2: `query_prot` is high exactly when `query_addr` is greater than or equal to the stored threshold, with no clock delay.
- R3: A strobe with `cmd_prot` low (memory-side instruction) gives no acknowledge, no readback and no state change.
- R4: Opcode 2'b10 with `cmd_prot` high reads the threshold at any `pe_level`, even while locked. One cycle later `cmd_ack` and `rd_valid` pulse, and `rd_addr` holds the threshold.
- R5: Opcode 2'b00 with field bits [7:6] = 2'b11 and `pe_level` high arms write-type commands for the current selection, and is acknowledged, unless locked.
- R6: Opcode 2'b01 with `pe_level` high loads field bits [6:0] as the threshold, and is acknowledged, only when armed and unlocked. Field bit 7 is ignored. When unarmed it is not acknowledged and the threshold stays unchanged.
- R7: Opcode 2'b11 with field 8'hFF and `pe_level` high resets the threshold to 127, and is acknowledged, only when armed and unlocked.
- R8: A write-type strobe (any opcode other than 2'b10) with `pe_level` low is not acknowledged and changes nothing.
- R9: Dropping `sel_active` clears the arm, and strobes while `sel_active` is low are ignored.
- R10: Opcode 2'b00 with field 8'h00 and `pe_level` high sets the lock and is acknowledged. From then on, arm, load, clear and lock are never acknowledged and the threshold never changes. Read still works.
- R11: Only reset clears the lock. After reset, arm and load are accepted again.
- R12: `cmd_ack` and `rd_valid` are one-cycle pulses, asserted only in the cycle after an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| sel_active | input | 1 | High while the device is selected |
| cmd_valid | input | 1 | One-cycle strobe of a decoded instruction |
| cmd_prot | input | 1 | Level of the protect-register select pin |
| cmd_op | input | 2 | Opcode bits |
| cmd_field | input | ADDR_W+1 | Address field of the instruction |
| pe_level | input | 1 | Level of the program-enable pin |
| query_addr | input | ADDR_W | Word address to test |
| query_prot | output | 1 | High when `query_addr` is protected |
| cmd_ack | output | 1 | Pulse: the last strobe was accepted |
| rd_valid | output | 1 | Pulse: `rd_addr` carries a readback |
| rd_addr | output | ADDR_W | Threshold returned by a read |

## Verification
The bench builds the block with its default 7-bit word address and 8-bit field. This small address space lets the bench sweep all 128 query addresses around several thresholds, including the extremes 0 and 127. At this width, the clear pattern 8'hFF and the lock pattern 8'h00 are exact field values. The arm decode also sees malformed fields that match neither pattern. A behavioural model predicts acknowledge, readback and protection on every clock. It covers runs before and after lock and across a mid-run reset.

// File: rtl/wpg_pkg.sv
`timescale 1ns/1ps
package wpg_pkg;

    localparam int unsigned DEF_ADDR_W = 7;
    localparam int unsigned OP_W       = 2;

    typedef enum logic [OP_W-1:0] {
        OPC_ZERO = 2'b00,
        OPC_LOAD = 2'b01,
        OPC_READ = 2'b10,
        OPC_WIPE = 2'b11
    } opc_e;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_READ,
        PK_ARM,
        PK_WIPE,
        PK_LOAD,
        PK_LOCK
    } pkind_e;

    typedef struct packed {
        pkind_e kind;
        logic   writes;   // command is write-type (needs arm for load/wipe)
    } pcmd_t;

    // Map opcode plus field shape onto a protect command kind.
    function automatic pkind_e classify(
        input opc_e op,
        input logic hi_pair_set,
        input logic all_set,
        input logic all_clear,
        input logic pe
    );
        pkind_e k;
        k = PK_NONE;
        case (op)
            OPC_READ: k = PK_READ;
            OPC_LOAD: if (pe) k = PK_LOAD;
            OPC_WIPE: if (pe && all_set) k = PK_WIPE;
            OPC_ZERO: begin
                if (pe && hi_pair_set)    k = PK_ARM;
                else if (pe && all_clear) k = PK_LOCK;
            end
            default: k = PK_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/wpg_decode.sv
`timescale 1ns/1ps
module wpg_decode
    import wpg_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned FIELD_W = ADDR_W + 1
) (
    input  logic               strobe,
    input  logic               sel_active,
    input  logic               prot_sel,
    input  logic [OP_W-1:0]    op,
    input  logic [FIELD_W-1:0] field,
    input  logic               pe,
    output pcmd_t              cmd
);

    logic   live;
    logic   hi_pair;
    logic   ones;
    logic   zeros;
    pkind_e kind;

    assign live    = strobe && sel_active && prot_sel;
    assign hi_pair = &field[FIELD_W-1 -: 2];
    assign ones    = &field;
    assign zeros   = ~|field;

    always_comb begin
        kind = PK_NONE;
        if (live) begin
            kind = classify(opc_e'(op), hi_pair, ones, zeros, pe);
        end
        cmd.kind   = kind;
        cmd.writes = (kind == PK_LOAD) || (kind == PK_WIPE);
    end

endmodule

// File: rtl/wpg_state.sv
`timescale 1ns/1ps
module wpg_state
    import wpg_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_active,
    input  pcmd_t             cmd,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] thresh_q,
    output logic              lock_q,
    output logic              armed_q,
    output logic              ack_q,
    output logic              rdv_q,
    output logic [ADDR_W-1:0] rd_q
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic accept;

    always_comb begin
        accept = 1'b0;
        case (cmd.kind)
            PK_READ:          accept = 1'b1;
            PK_ARM, PK_LOCK:  accept = !lock_q;
            PK_LOAD, PK_WIPE: accept = cmd.writes && armed_q && !lock_q;
            default:          accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh_q <= TOP_ADDR;
            lock_q   <= 1'b0;
            armed_q  <= 1'b0;
            ack_q    <= 1'b0;
            rdv_q    <= 1'b0;
            rd_q     <= '0;
        end else begin
            ack_q <= accept;
            rdv_q <= (cmd.kind == PK_READ);
            if (cmd.kind == PK_READ) begin
                rd_q <= thresh_q;
            end
            if (accept && cmd.kind == PK_LOAD) begin
                thresh_q <= load_addr;
            end else if (accept && cmd.kind == PK_WIPE) begin
                thresh_q <= TOP_ADDR;
            end
            if (accept && cmd.kind == PK_LOCK) begin
                lock_q <= 1'b1;
            end
            if (!sel_active || (accept && cmd.kind == PK_LOCK)) begin
                armed_q <= 1'b0;
            end else if (accept && cmd.kind == PK_ARM) begin
                armed_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wpg_compare.sv
`timescale 1ns/1ps
module wpg_compare
    import wpg_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] query,
    input  logic [ADDR_W-1:0] thresh,
    output logic              hit
);

    assign hit = (query >= thresh);

endmodule

// File: rtl/wp_threshold_guard.sv
`timescale 1ns/1ps
module wp_threshold_guard
    import wpg_pkg::*;
#(
    parameter int unsigned ADDR_W  = DEF_ADDR_W,
    localparam int unsigned FIELD_W = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_active,
    input  logic               cmd_valid,
    input  logic               cmd_prot,
    input  logic [OP_W-1:0]    cmd_op,
    input  logic [FIELD_W-1:0] cmd_field,
    input  logic               pe_level,
    input  logic [ADDR_W-1:0]  query_addr,
    output logic               query_prot,
    output logic               cmd_ack,
    output logic               rd_valid,
    output logic [ADDR_W-1:0]  rd_addr
);

    pcmd_t             dec_cmd;
    logic [ADDR_W-1:0] thresh_q;
    logic              lock_q;
    logic              armed_q;

    wpg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .strobe     (cmd_valid),
        .sel_active (sel_active),
        .prot_sel   (cmd_prot),
        .op         (cmd_op),
        .field      (cmd_field),
        .pe         (pe_level),
        .cmd        (dec_cmd)
    );

    wpg_state #(.ADDR_W(ADDR_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .sel_active (sel_active),
        .cmd        (dec_cmd),
        .load_addr  (cmd_field[ADDR_W-1:0]),
        .thresh_q   (thresh_q),
        .lock_q     (lock_q),
        .armed_q    (armed_q),
        .ack_q      (cmd_ack),
        .rdv_q      (rd_valid),
        .rd_q       (rd_addr)
    );

    wpg_compare #(.ADDR_W(ADDR_W)) u_compare (
        .query  (query_addr),
        .thresh (thresh_q),
        .hit    (query_prot)
    );

endmodule

// File: rtl/wpg_checker.sv
`timescale 1ns/1ps
module wpg_checker #(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_active,
    input logic              cmd_valid,
    input logic              cmd_prot,
    input logic [1:0]        cmd_op,
    input logic              pe_level,
    input logic              cmd_ack,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [ADDR_W-1:0] thresh_q,
    input logic              lock_q,
    input logic              armed_q
);

    // R12
    ack_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |-> $past(cmd_valid && sel_active && cmd_prot));

    // R3
    mem_side_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_prot) |=> (!cmd_ack && !rd_valid));

    // R4
    prot_read_acked_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && sel_active && cmd_prot && cmd_op == 2'b10)
        |=> (cmd_ack && rd_valid && rd_addr == $past(thresh_q)));

    // R8
    pe_low_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_prot && !pe_level && cmd_op != 2'b10) |=> !cmd_ack);

    // R10
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R10
    lock_freezes_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (thresh_q == $past(thresh_q)));

    // R6
    thr_move_armed_chk: assert property (@(posedge clk) disable iff (rst)
        (thresh_q != $past(thresh_q)) |-> $past(armed_q));

endmodule

bind wp_threshold_guard wpg_checker #(.ADDR_W(ADDR_W)) u_wpg_checker (
    .clk        (clk),
    .rst        (rst),
    .sel_active (sel_active),
    .cmd_valid  (cmd_valid),
    .cmd_prot   (cmd_prot),
    .cmd_op     (cmd_op),
    .pe_level   (pe_level),
    .cmd_ack    (cmd_ack),
    .rd_valid   (rd_valid),
    .rd_addr    (rd_addr),
    .thresh_q   (thresh_q),
    .lock_q     (lock_q),
    .armed_q    (armed_q)
);

// File: tb/wp_threshold_guard_bench.sv
`timescale 1ns/1ps
module wp_threshold_guard_bench;

    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_active = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_prot = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW:0]   cmd_field = '0;
    logic          pe_level = 1'b0;
    logic [AW-1:0] query_addr = '0;
    logic          query_prot;
    logic          cmd_ack;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;

    int n_chk = 0;
    int n_bad = 0;

    int m_thr  = 127;
    bit m_lock = 0;
    bit m_arm  = 0;
    bit x_ack  = 0;
    bit x_rdv  = 0;
    int x_rd   = 0;

    always #2.5 clk = ~clk;

    wp_threshold_guard #(.ADDR_W(AW)) u_wp_threshold_guard (
        .clk        (clk),
        .rst        (rst),
        .sel_active (sel_active),
        .cmd_valid  (cmd_valid),
        .cmd_prot   (cmd_prot),
        .cmd_op     (cmd_op),
        .cmd_field  (cmd_field),
        .pe_level   (pe_level),
        .query_addr (query_addr),
        .query_prot (query_prot),
        .cmd_ack    (cmd_ack),
        .rd_valid   (rd_valid),
        .rd_addr    (rd_addr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "ack", int'(cmd_ack), int'(x_ack));
        chk(tag, "rd_valid", int'(rd_valid), int'(x_rdv));
        if (x_rdv) chk(tag, "rd_addr", int'(rd_addr), x_rd);
        chk(tag, "query_prot", int'(query_prot), int'(int'(query_addr) >= m_thr));
    endtask

    // One clock: drive at negedge, predict, advance, compare at next negedge.
    task automatic step(input string tag, input bit v, input bit sel, input bit p,
                        input bit [1:0] op, input bit [7:0] f, input bit pe, input int q);
        int  n_thr;
        bit  n_lock;
        bit  n_arm;
        bit  e_ack;
        bit  e_rdv;
        int  e_rd;
        sel_active = sel;
        cmd_valid  = v;
        cmd_prot   = p;
        cmd_op     = op;
        cmd_field  = f;
        pe_level   = pe;
        query_addr = AW'(q);
        n_thr = m_thr; n_lock = m_lock; n_arm = m_arm;
        e_ack = 0; e_rdv = 0; e_rd = x_rd;
        if (v && sel && p) begin
            if (op == 2'b10) begin
                e_ack = 1; e_rdv = 1; e_rd = m_thr;
            end else if (pe && op == 2'b00 && f[7:6] == 2'b11) begin
                if (!m_lock) begin e_ack = 1; n_arm = 1; end
            end else if (pe && op == 2'b00 && f == 8'h00) begin
                if (!m_lock) begin e_ack = 1; n_lock = 1; n_arm = 0; end
            end else if (pe && op == 2'b01) begin
                if (m_arm && !m_lock) begin e_ack = 1; n_thr = int'(f) % 128; end
            end else if (pe && op == 2'b11 && f == 8'hFF) begin
                if (m_arm && !m_lock) begin e_ack = 1; n_thr = 127; end
            end
        end
        if (!sel) n_arm = 0;
        @(posedge clk);
        m_thr = n_thr; m_lock = n_lock; m_arm = n_arm;
        x_ack = e_ack; x_rdv = e_rdv; x_rd = e_rd;
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input string tag, input int q);
        step(tag, 0, 1, 1, 2'b00, 8'h00, 0, q);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_thr = 127; m_lock = 0; m_arm = 0;
        x_ack = 0; x_rdv = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        query_addr = 7'd126;
        #0.1;
        chk("R1", "reset ack", int'(cmd_ack), 0);
        chk("R1", "reset rd_valid", int'(rd_valid), 0);
        chk("R1", "reset q126", int'(query_prot), 0);
        idle("R1", 127);
        // R4 read of reset threshold, PE low
        step("R4", 1, 1, 1, 2'b10, 8'h00, 0, 0);
        idle("R12", 0);
        // R6 load without arm is ignored
        step("R6", 1, 1, 1, 2'b01, 8'h10, 1, 16);
        idle("R6", 16);
        // R3 memory-side strobe shaped like arm, then load still refused
        step("R3", 1, 1, 0, 2'b00, 8'hC0, 1, 16);
        step("R3", 1, 1, 1, 2'b01, 8'h10, 1, 16);
        // R5 arm
        step("R5", 1, 1, 1, 2'b00, 8'hC0, 1, 0);
        // R8 load with PE low
        step("R8", 1, 1, 1, 2'b01, 8'h20, 0, 32);
        step("R8", 1, 1, 1, 2'b11, 8'hFF, 0, 32);
        // R6 load 0x20 with field bit 7 set
        step("R6", 1, 1, 1, 2'b01, 8'hA0, 1, 32);
        // R2 sweep around threshold 32
        for (int a = 0; a < 128; a++) idle("R2", a);
        step("R4", 1, 1, 1, 2'b10, 8'h55, 1, 31);
        // R9 deselect drops arm; strobe while deselected ignored
        step("R9", 1, 0, 1, 2'b01, 8'h05, 1, 5);
        step("R9", 1, 1, 1, 2'b01, 8'h05, 1, 5);
        idle("R9", 31);
        // R7 clear after arm
        step("R5", 1, 1, 1, 2'b00, 8'hC3, 1, 0);
        step("R7", 1, 1, 1, 2'b11, 8'hFF, 1, 126);
        idle("R7", 127);
        // R7 clear with wrong field ignored
        step("R6", 1, 1, 1, 2'b01, 8'h40, 1, 64);
        step("R7", 1, 1, 1, 2'b11, 8'hFE, 1, 63);
        // R5 malformed arm field is neither arm nor lock
        step("R9", 0, 0, 1, 2'b00, 8'h00, 0, 0);
        step("R5", 1, 1, 1, 2'b00, 8'h40, 1, 0);
        step("R5", 1, 1, 1, 2'b01, 8'h00, 1, 0);
        // R2 boundary threshold 0 protects all
        step("R5", 1, 1, 1, 2'b00, 8'hC0, 1, 0);
        step("R6", 1, 1, 1, 2'b01, 8'h00, 1, 0);
        for (int a = 0; a < 128; a += 9) idle("R2", a);
        // R10 lock
        step("R10", 1, 1, 1, 2'b00, 8'h00, 1, 0);
        step("R10", 1, 1, 1, 2'b00, 8'hC0, 1, 0);
        step("R10", 1, 1, 1, 2'b01, 8'h30, 1, 0);
        step("R10", 1, 1, 1, 2'b11, 8'hFF, 1, 0);
        step("R10", 1, 1, 1, 2'b00, 8'h00, 1, 0);
        step("R9", 0, 0, 1, 2'b00, 8'h00, 0, 0);
        step("R10", 1, 1, 1, 2'b00, 8'hC0, 1, 0);
        step("R10", 1, 1, 1, 2'b01, 8'h7F, 1, 0);
        step("R4", 1, 1, 1, 2'b10, 8'h00, 0, 0);
        idle("R10", 0);
        // R11 reset clears lock
        do_reset();
        step("R11", 0, 1, 1, 2'b00, 8'h00, 0, 126);
        step("R11", 1, 1, 1, 2'b00, 8'hC0, 1, 0);
        step("R11", 1, 1, 1, 2'b01, 8'h40, 1, 63);
        for (int a = 60; a < 70; a++) idle("R2", a);
        step("R4", 1, 1, 1, 2'b10, 8'h00, 1, 64);
        idle("R12", 64);
        finish_run();
    end

endmodule